// File: doc/BRIEF.md
# Zero-Turnaround Pipelined SRAM Core

This block is a synchronous single-port memory. Reads and writes use the same fixed two-stage pipeline. A command's address, direction and byte-lane mask are captured on one rising edge. The matching data beat happens at the second rising edge after that one. Because both directions have the same latency, a controller can issue reads and writes in any mix on consecutive cycles and the shared data bus never needs an idle cycle to turn around.

The data bus is modelled as three separate signals: an input word, an output word and an output-enable flag. A clock-stall input freezes the whole pipeline. Three chip selects of mixed polarity gate the start of new operations. An asynchronous output-enable input can silence the bus at any moment. Burst addresses are generated outside the block: an "advance" cycle repeats the kind of the last loaded command at whatever address is presented.

Command tracking is held by a small state machine, `burst_mode`, with three named states:
- `OP_IDLE`: no operation.
- `OP_READ`: a read is in progress.
- `OP_WRITE`: a write is in progress.

It has four named transitions:
- `LOAD_RD`: a selected load with read direction enters `OP_READ`.
- `LOAD_WR`: a selected load with write direction enters `OP_WRITE`.
- `LOAD_DESEL`: a load while deselected enters `OP_IDLE`.
- `ADVANCE`: `load_n` high keeps the current state.

Reset returns the machine to `OP_IDLE`. Each pipeline stage carries one of the same three operation kinds.

Top module: `zt_sram_core`

## Requirements
- R1: A read loaded at rising edge n drives the word stored at its address on `dq_out`, with `dq_oe` high while `oe_n` is low. This holds from just after edge n+2 until edge n+3.
- R2: A write loaded at edge n stores `dq_in` as sampled at edge n+2. The mask `be_n` is sampled at edge n and is active low: bit i enables bits [8i+7:8i]. A lane whose bit is 1 keeps its old contents.
- R3: Reads and writes issued on consecutive cycles in any order all complete, with no idle cycles inserted between them.
- R4: While `suspend` is high, every input except `oe_n` is ignored. All pipeline and output registers hold their values and the array is not written. Operation resumes exactly where it stopped.
- R5: A load cycle (`load_n`=0) starts an operation only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. If any one of the three is inactive, the cycle is a deselect.
- R6: An operation already in the pipeline completes even if later cycles deselect the device.
- R7: `dq_oe` is low from just after edge n+2 whenever the command at edge n was a write or a deselect.
- R8: `oe_n` high forces `dq_oe` low immediately, without a clock. The pipeline and the read data are not disturbed.
- R9: An advance cycle (`load_n`=1) repeats the kind of the last load, using the `addr` and `be_n` of that cycle and ignoring the chip selects. After reset or after a deselect load, an advance is a no-op.
- R10: A read issued on the cycle right after a write to the same address returns the newly written data.
- R11: Reset empties the pipeline, so `dq_oe` is low during reset and stays low afterwards until a new read reaches the data stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| suspend | input | 1 | Stall: high freezes the pipeline |
| load_n | input | 1 | Low loads a new command; high advances the current one |
| wr_n | input | 1 | Direction: 1 read, 0 write |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| addr | input | ADDR_W (6) | Word address |
| be_n | input | LANES (2) | Byte-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | LANES*LANE_W (16) | Write data from the bus |
| dq_out | output | LANES*LANE_W (16) | Read data to the bus |
| dq_oe | output | 1 | High when the core drives the bus |

## Verification
The assertions check the following on every cycle:
- a read in the data stage always raises the output-valid register one edge later, and any other kind clears it;
- a stall freezes every pipeline stage and the output register;
- a load with any chip select inactive injects an idle stage;
- an advance leaves the mode register unchanged;
- stage contents move forward intact.

Only the bench scenarios can show the following:
- data values;
- byte-lane merging;
- that a write stalled at its data edge takes the word presented after the stall;
- the asynchronous effect of `oe_n`;
- read-after-write freshness.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Number of register stages between command capture and data beat.
    localparam int unsigned PIPE_DEPTH = 2;
endpackage

// File: rtl/zt_cmd_decode.sv
module zt_cmd_decode
    import zt_sram_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic suspend,
    input  logic load_n,
    input  logic wr_n,
    input  logic sel_a_n,
    input  logic sel_b,
    input  logic sel_c_n,
    output op_e  new_op
);
    op_e  burst_mode, mode_d, load_kind;
    logic selected;

    always_comb begin
        selected  = !sel_a_n && sel_b && !sel_c_n;
        load_kind = !selected ? OP_IDLE : (wr_n ? OP_READ : OP_WRITE);
    end

    // next-state logic: LOAD_RD / LOAD_WR / LOAD_DESEL on a load, ADVANCE otherwise
    always_comb begin
        mode_d = burst_mode;
        unique case (burst_mode)
            OP_IDLE:  if (!load_n) mode_d = load_kind;
            OP_READ:  if (!load_n) mode_d = load_kind;
            OP_WRITE: if (!load_n) mode_d = load_kind;
            default:  mode_d = OP_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        burst_mode <= OP_IDLE;
        else if (!suspend) burst_mode <= mode_d;
    end

    // output process
    always_comb begin
        new_op = load_n ? burst_mode : load_kind;
    end

    // R9: an advance cycle never changes the remembered kind
    assert_advance_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !suspend) |=> (burst_mode == $past(burst_mode)));

    // R4: a stall freezes the mode register
    assert_mode_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        suspend |=> $stable(burst_mode));
endmodule

// File: rtl/zt_cmd_pipe.sv
module zt_cmd_pipe
    import zt_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              suspend,
    input  op_e               new_op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  be_n,
    output op_e               head_op,
    output op_e               tail_op,
    output logic [ADDR_W-1:0] tail_addr,
    output logic [LANES-1:0]  tail_be_n
);
    localparam int unsigned LAST = PIPE_DEPTH - 1;

    op_e               op_q   [PIPE_DEPTH];
    logic [ADDR_W-1:0] addr_q [PIPE_DEPTH];
    logic [LANES-1:0]  be_q   [PIPE_DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < PIPE_DEPTH; k++) begin
                op_q[k]   <= OP_IDLE;
                addr_q[k] <= '0;
                be_q[k]   <= '1;
            end
        end else if (!suspend) begin
            for (int k = PIPE_DEPTH - 1; k > 0; k--) begin
                op_q[k]   <= op_q[k-1];
                addr_q[k] <= addr_q[k-1];
                be_q[k]   <= be_q[k-1];
            end
            op_q[0]   <= new_op;
            addr_q[0] <= addr;
            be_q[0]   <= be_n;
        end
    end

    assign head_op   = op_q[0];
    assign tail_op   = op_q[LAST];
    assign tail_addr = addr_q[LAST];
    assign tail_be_n = be_q[LAST];

    for (genvar g = 0; g < PIPE_DEPTH; g++) begin : g_stage_chk
        // R4: every stage holds while stalled
        assert_stage_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            suspend |=> ($stable(op_q[g]) && $stable(addr_q[g]) && $stable(be_q[g])));
        if (g > 0) begin : g_fwd
            // R6: stage contents advance unchanged, whatever the new command is
            assert_inflight_R6: assert property (@(posedge clk) disable iff (!rst_n)
                !suspend |=> (op_q[g] == $past(op_q[g-1]) && addr_q[g] == $past(addr_q[g-1])));
        end
    end
endmodule

// File: rtl/zt_byte_array.sv
module zt_byte_array #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 2,
    parameter int unsigned LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [LANES-1:0]        lane_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);
    localparam int unsigned WORDS = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [WORDS];

        always_ff @(posedge clk) begin
            if (wr_en && lane_en[g])
                mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        end

        assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
    end
endmodule

// File: rtl/zt_sram_core.sv
module zt_sram_core
    import zt_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 2,
    parameter int unsigned LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    suspend,
    input  logic                    load_n,
    input  logic                    wr_n,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        be_n,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] dq_in,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic                    dq_oe
);
    localparam int unsigned DATA_W = LANES * LANE_W;

    op_e               new_op, head_op, tail_op;
    logic [ADDR_W-1:0] tail_addr;
    logic [LANES-1:0]  tail_be_n;
    logic [DATA_W-1:0] arr_rd;
    logic              arr_we;
    logic              rd_vld_q;
    logic [DATA_W-1:0] rd_data_q;

    zt_cmd_decode u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .suspend (suspend),
        .load_n  (load_n),
        .wr_n    (wr_n),
        .sel_a_n (sel_a_n),
        .sel_b   (sel_b),
        .sel_c_n (sel_c_n),
        .new_op  (new_op)
    );

    zt_cmd_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .suspend   (suspend),
        .new_op    (new_op),
        .addr      (addr),
        .be_n      (be_n),
        .head_op   (head_op),
        .tail_op   (tail_op),
        .tail_addr (tail_addr),
        .tail_be_n (tail_be_n)
    );

    assign arr_we = (tail_op == OP_WRITE) && !suspend;

    zt_byte_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .wr_en   (arr_we),
        .lane_en (~tail_be_n),
        .wr_addr (tail_addr),
        .wr_data (dq_in),
        .rd_addr (tail_addr),
        .rd_data (arr_rd)
    );

    // Output register: the data stage of the read path.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_vld_q  <= 1'b0;
            rd_data_q <= '0;
        end else if (!suspend) begin
            rd_vld_q <= (tail_op == OP_READ);
            if (tail_op == OP_READ) rd_data_q <= arr_rd;
        end
    end

    assign dq_out = rd_data_q;
    assign dq_oe  = rd_vld_q && !oe_n;

    // R1: a read in the data stage always produces valid output one edge later
    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_op == OP_READ && !suspend) |=> rd_vld_q);

    // R7: a write or deselect in the data stage releases the bus one edge later
    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_op != OP_READ && !suspend) |=> !rd_vld_q);

    // R4: output register frozen while stalled
    assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        suspend |=> ($stable(rd_vld_q) && $stable(rd_data_q)));

    // R5: a load with any select inactive injects an idle stage
    assert_desel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!suspend && !load_n && (sel_a_n || !sel_b || sel_c_n)) |=> (head_op == OP_IDLE));
endmodule

// File: tb/tb_zt_sram_core.sv
module tb_zt_sram_core;
    // Row fields: {ld_n, wr_n, cs[3], addr[6], be_n[2], din[16], sus, exp_oe, exp_dat[16]}
    // Expectations describe the outputs sampled after the edge that takes the row.
    localparam int ROWS = 19;
    localparam logic [46:0] VEC [ROWS] = '{
        {1'b0,1'b0,3'b010,6'd1,2'b00,16'h0000,1'b0,1'b0,16'h0000},
        {1'b0,1'b0,3'b010,6'd2,2'b00,16'h0000,1'b0,1'b0,16'h0000},
        {1'b0,1'b0,3'b010,6'd2,2'b01,16'h1111,1'b0,1'b0,16'h0000},
        {1'b0,1'b1,3'b010,6'd1,2'b00,16'h2222,1'b0,1'b0,16'h0000},
        {1'b0,1'b1,3'b010,6'd2,2'b00,16'hAB33,1'b0,1'b0,16'h0000},
        {1'b0,1'b0,3'b010,6'd3,2'b00,16'h0000,1'b0,1'b1,16'h1111},
        {1'b0,1'b1,3'b010,6'd3,2'b00,16'h0000,1'b0,1'b1,16'hAB22},
        {1'b0,1'b1,3'b110,6'd0,2'b00,16'h4444,1'b0,1'b0,16'h0000},
        {1'b0,1'b1,3'b010,6'd1,2'b00,16'h0000,1'b0,1'b1,16'h4444},
        {1'b1,1'b1,3'b010,6'd2,2'b00,16'h0000,1'b0,1'b0,16'h0000},
        {1'b0,1'b0,3'b010,6'd1,2'b00,16'hEEEE,1'b1,1'b0,16'h0000},
        {1'b0,1'b1,3'b000,6'd1,2'b00,16'h0000,1'b0,1'b1,16'h1111},
        {1'b0,1'b1,3'b011,6'd1,2'b00,16'h0000,1'b0,1'b1,16'hAB22},
        {1'b0,1'b1,3'b110,6'd0,2'b00,16'h0000,1'b0,1'b0,16'h0000},
        {1'b0,1'b1,3'b010,6'd1,2'b00,16'h0000,1'b0,1'b0,16'h0000},
        {1'b0,1'b1,3'b110,6'd0,2'b00,16'h0000,1'b0,1'b0,16'h0000},
        {1'b1,1'b1,3'b010,6'd1,2'b00,16'h0000,1'b0,1'b1,16'h1111},
        {1'b0,1'b1,3'b110,6'd0,2'b00,16'h0000,1'b0,1'b0,16'h0000},
        {1'b0,1'b1,3'b110,6'd0,2'b00,16'h0000,1'b0,1'b0,16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        suspend = 1'b0, load_n = 1'b0, wr_n = 1'b1;
    logic        sel_a_n = 1'b1, sel_b = 1'b1, sel_c_n = 1'b0;
    logic [5:0]  addr = '0;
    logic [1:0]  be_n = '1;
    logic        oe_n = 1'b0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic        dq_oe;
    int          checks = 0, failures = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    zt_sram_core dut (
        .clk(clk), .rst_n(rst_n), .suspend(suspend), .load_n(load_n), .wr_n(wr_n),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .addr(addr), .be_n(be_n),
        .oe_n(oe_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drv(input logic ld, input logic wr, input logic [2:0] cs, input logic [5:0] a,
                       input logic [1:0] be, input logic [15:0] din, input logic sus);
        load_n = ld; wr_n = wr; {sel_a_n, sel_b, sel_c_n} = cs;
        addr = a; be_n = be; dq_in = din; suspend = sus;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic string row_req(input int i);
        case (i)
            0, 1, 2, 3, 4: return "R2 byte-lane write";
            5:             return "R1 read latency";
            6:             return "R3 alternation";
            7:             return "R7 write releases bus";
            8:             return "R10 read after write";
            9:             return "R6 pending read across deselect";
            10:            return "R4 stall holds output";
            11:            return "R4 resume after stall";
            12:            return "R9 advance repeats read";
            13, 14:        return "R5 partial select";
            15:            return "R7 deselect releases bus";
            16:            return "R4 stalled write ignored";
            default:       return "R9 advance after deselect";
        endcase
    endfunction

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 oe during reset", {15'd0, dq_oe}, 16'd0);
        rst_n = 1'b1;
        chk("R11 oe after reset", {15'd0, dq_oe}, 16'd0);

        // table walk
        for (int i = 0; i < ROWS; i++) begin
            logic [46:0] v;
            v = VEC[i];
            drv(v[46], v[45], v[44:42], v[41:36], v[35:34], v[33:18], v[17]);
            step();
            chk(row_req(i), {15'd0, dq_oe}, {15'd0, v[16]});
            if (v[16]) chk(row_req(i), dq_out, v[15:0]);
        end

        // R4: write stalled at its data edge takes the word presented after the stall
        drv(0, 0, 3'b010, 6'd5, 2'b00, 16'h0000, 0); step();
        drv(0, 1, 3'b110, 6'd0, 2'b00, 16'h0000, 0); step();
        drv(0, 1, 3'b110, 6'd0, 2'b00, 16'hDEAD, 1); step();
        drv(0, 1, 3'b110, 6'd0, 2'b00, 16'hDEAD, 1); step();
        drv(0, 1, 3'b110, 6'd0, 2'b00, 16'h5A5A, 0); step();
        drv(0, 1, 3'b010, 6'd5, 2'b00, 16'h0000, 0); step();
        drv(0, 1, 3'b110, 6'd0, 2'b00, 16'h0000, 0); step();
        step();
        chk("R4 stalled write data oe", {15'd0, dq_oe}, 16'd1);
        chk("R4 stalled write data", dq_out, 16'h5A5A);

        // R8: asynchronous output enable
        drv(0, 1, 3'b010, 6'd1, 2'b00, 16'h0000, 0); step();
        drv(0, 1, 3'b110, 6'd0, 2'b00, 16'h0000, 0); step();
        step();
        chk("R8 read visible", {15'd0, dq_oe}, 16'd1);
        oe_n = 1'b1; #1;
        chk("R8 oe_n forces off", {15'd0, dq_oe}, 16'd0);
        oe_n = 1'b0; #1;
        chk("R8 oe restored", {15'd0, dq_oe}, 16'd1);
        chk("R8 data undisturbed", dq_out, 16'h1111);
        step();

        // R11: reset flushes a read in flight
        drv(0, 1, 3'b010, 6'd1, 2'b00, 16'h0000, 0); step();
        drv(0, 1, 3'b110, 6'd0, 2'b00, 16'h0000, 0);
        rst_n = 1'b0; #1;
        chk("R11 oe in reset", {15'd0, dq_oe}, 16'd0);
        step();
        rst_n = 1'b1;
        step(); step();
        chk("R11 flushed read", {15'd0, dq_oe}, 16'd0);

        // R9: advance straight after reset is a no-op
        drv(1, 1, 3'b010, 6'd1, 2'b00, 16'h0000, 0); step();
        drv(0, 1, 3'b110, 6'd0, 2'b00, 16'h0000, 0); step();
        step();
        chk("R9 advance after reset", {15'd0, dq_oe}, 16'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule